// File: doc/BRIEF.md
# IR Carrier and PWM Output Generator

This block drives one output pin with a timer-shaped waveform. Two phase timers (a high-width timer and a low-width timer) alternate to form a rectangular wave. A third auto-reloading counter produces a 50% duty carrier. In modulated mode, the carrier is gated onto the pin during the low phase, which produces an infrared remote burst pattern. In plain mode, the carrier counter keeps running on its own as a free timer.

All counting advances on a one-cycle strobe `tick_i` from an external prescaler. When the block is disabled, every counter restarts and the pin is handed back to a general-purpose port data bit. A low-only mode ignores the high-width reload, so both phases take their length from the low-width reload alone. Each timer reports the end of its period with a one-cycle flag.

Top module: `ir_pwm_gen`

## Requirements
- R1: While `en_i` is 0, `pin_o` equals `port_bit_i` in the same cycle, all three flags stay 0, and the timers restart. The first enabled tick starts a fresh high phase, and the carrier starts at level 0.
- R2: When enabled with `mod_en_i`=0 and `low_only_i`=0, the pin is 1 for `hi_reload_i`+1 ticks and then 0 for `lo_reload_i`+1 ticks, repeating. A reload of 0 gives a one-tick phase.
- R3: Timers change state only on cycles where `tick_i` is 1. Cycles without a tick leave the pin and the counts unchanged.
- R4: The carrier level toggles every `car_reload_i`+1 ticks, whatever the state of `mod_en_i`. It runs as an independent auto-reload timer while modulation is off.
- R5: With `mod_en_i`=1, the pin is 1 during the high phase. During the low phase the pin equals the carrier level.
- R6: With `low_only_i`=1, `hi_reload_i` has no effect. Both the high and low phases last `lo_reload_i`+1 ticks.
- R7: A reload value that changes in the middle of a phase is used only when a phase of that kind next starts. The phase in progress keeps its length.
- R8: Each flag is a one-cycle pulse in the cycle after the terminal tick. `hi_done_o` marks the end of a high phase, `lo_done_o` the end of a low phase, and `car_done_o` a carrier reload. `hi_done_o` and `lo_done_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count strobe from prescaler |
| en_i | input | 1 | Waveform generator enable |
| mod_en_i | input | 1 | Carrier modulation of low phase |
| low_only_i | input | 1 | Use low-width reload for both phases |
| hi_reload_i | input | CNT_W | High phase length minus one, in ticks |
| lo_reload_i | input | CNT_W | Low phase length minus one, in ticks |
| car_reload_i | input | CAR_W | Carrier half period minus one, in ticks |
| port_bit_i | input | 1 | Pin level while disabled |
| pin_o | output | 1 | Output pin level |
| hi_done_o | output | 1 | High phase complete pulse |
| lo_done_o | output | 1 | Low phase complete pulse |
| car_done_o | output | 1 | Carrier reload pulse |

## Verification
The assertions assume three things about the inputs:
- `en_i` is held low while reset is active, so the first cycles after reset never count as enabled history.
- `tick_i` is a synchronous strobe that is sampled only on the clock edge.
- Any change in the pin with modulation off can be explained by a phase change alone, which requires `mod_en_i` and `en_i` to be steady across the cycle checked.

The stimulus keeps to these assumptions:
- It changes every input just after the falling edge.
- It keeps enable low through reset.
- It switches the mode bits only between runs of many ticks.

// File: rtl/ir_pwm_pkg.sv
package ir_pwm_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;
endpackage

// File: rtl/ir_width_timer.sv
module ir_width_timer
  import ir_pwm_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic         low_only_i,
  input  logic [W-1:0] hi_rl_i,
  input  logic [W-1:0] lo_rl_i,
  output phase_e       phase_o,
  output logic         hi_done_o,
  output logic         lo_done_o
);
  logic [W-1:0] cnt_q;
  phase_e       ph_q, nxt_ph;
  logic [W-1:0] nxt_rl, start_rl;
  logic         term;

  assign term     = tick_i && (cnt_q == '0);
  assign nxt_ph   = (ph_q == PH_HIGH) ? PH_LOW : PH_HIGH;
  // high phase borrows the low reload in low-only mode
  assign start_rl = low_only_i ? lo_rl_i : hi_rl_i;
  assign nxt_rl   = (nxt_ph == PH_HIGH) ? start_rl : lo_rl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= PH_HIGH;
      cnt_q     <= '0;
      hi_done_o <= 1'b0;
      lo_done_o <= 1'b0;
    end else if (!en_i) begin
      ph_q      <= PH_HIGH;
      cnt_q     <= start_rl;
      hi_done_o <= 1'b0;
      lo_done_o <= 1'b0;
    end else begin
      hi_done_o <= term && (ph_q == PH_HIGH);
      lo_done_o <= term && (ph_q == PH_LOW);
      if (term) begin
        ph_q  <= nxt_ph;
        cnt_q <= nxt_rl;
      end else if (tick_i) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign phase_o = ph_q;

  assert_hold_without_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> ($stable(cnt_q) && $stable(ph_q)));

  assert_done_needs_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_done_o || lo_done_o) |-> $past(en_i && tick_i));

  assert_done_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hi_done_o, lo_done_o}));

  assert_disable_restart_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (ph_q == PH_HIGH) && !hi_done_o && !lo_done_o);
endmodule

// File: rtl/ir_carrier_cnt.sv
module ir_carrier_cnt #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic [W-1:0] rl_i,
  output logic         car_o,
  output logic         done_o
);
  logic [W-1:0] cnt_q;
  logic         term;

  assign term = tick_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      car_o  <= 1'b0;
      done_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= rl_i;
      car_o  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= term;
      if (term) begin
        cnt_q <= rl_i;
        car_o <= ~car_o;
      end else if (tick_i) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assert_toggle_on_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (car_o != $past(car_o)));

  assert_steady_between_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !done_o) |-> $stable(car_o));
endmodule

// File: rtl/ir_pin_mux.sv
module ir_pin_mux
  import ir_pwm_pkg::*;
(
  input  logic   en_i,
  input  logic   port_bit_i,
  input  logic   mod_en_i,
  input  phase_e phase_i,
  input  logic   car_i,
  output logic   pin_o
);
  logic wave;

  always_comb begin
    if (phase_i == PH_HIGH) wave = 1'b1;
    else                    wave = mod_en_i & car_i;
    pin_o = en_i ? wave : port_bit_i;
  end
endmodule

// File: rtl/ir_pwm_gen.sv
module ir_pwm_gen
  import ir_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned CAR_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             mod_en_i,
  input  logic             low_only_i,
  input  logic [CNT_W-1:0] hi_reload_i,
  input  logic [CNT_W-1:0] lo_reload_i,
  input  logic [CAR_W-1:0] car_reload_i,
  input  logic             port_bit_i,
  output logic             pin_o,
  output logic             hi_done_o,
  output logic             lo_done_o,
  output logic             car_done_o
);
  phase_e phase;
  logic   car;

  ir_width_timer #(.W(CNT_W)) i_width_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .tick_i     (tick_i),
    .low_only_i (low_only_i),
    .hi_rl_i    (hi_reload_i),
    .lo_rl_i    (lo_reload_i),
    .phase_o    (phase),
    .hi_done_o  (hi_done_o),
    .lo_done_o  (lo_done_o)
  );

  ir_carrier_cnt #(.W(CAR_W)) i_carrier_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .tick_i (tick_i),
    .rl_i   (car_reload_i),
    .car_o  (car),
    .done_o (car_done_o)
  );

  ir_pin_mux i_pin_mux (
    .en_i       (en_i),
    .port_bit_i (port_bit_i),
    .mod_en_i   (mod_en_i),
    .phase_i    (phase),
    .car_i      (car),
    .pin_o      (pin_o)
  );

  // plain mode: pin edges only where a phase closed
  assert_plain_edges_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !mod_en_i && !$past(mod_en_i) && (pin_o != $past(pin_o)))
      |-> (hi_done_o || lo_done_o));

  assert_high_phase_pin_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && lo_done_o) |-> pin_o);
endmodule

// File: tb/test_ir_pwm_gen.sv
`timescale 1ns/1ps
module test_ir_pwm_gen;
  localparam int CNT_W = 8;
  localparam int CAR_W = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tick_i = 1'b0, en_i = 1'b0, mod_en_i = 1'b0, low_only_i = 1'b0, port_bit_i = 1'b0;
  logic [CNT_W-1:0] hi_reload_i = '0, lo_reload_i = '0;
  logic [CAR_W-1:0] car_reload_i = '0;
  logic pin_o, hi_done_o, lo_done_o, car_done_o;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit finished = 0;

  // behavioural reference state
  int m_ph, m_cnt, m_ccnt, m_car, m_hd, m_ld, m_cd;

  always #4 clk = ~clk;

  ir_pwm_gen #(.CNT_W(CNT_W), .CAR_W(CAR_W)) i_ir_pwm_gen (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .en_i(en_i), .mod_en_i(mod_en_i),
    .low_only_i(low_only_i), .hi_reload_i(hi_reload_i), .lo_reload_i(lo_reload_i),
    .car_reload_i(car_reload_i), .port_bit_i(port_bit_i), .pin_o(pin_o),
    .hi_done_o(hi_done_o), .lo_done_o(lo_done_o), .car_done_o(car_done_o)
  );

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 1; m_cnt = 0; m_ccnt = 0; m_car = 0; m_hd = 0; m_ld = 0; m_cd = 0;
    end else if (!en_i) begin
      m_ph = 1; m_cnt = low_only_i ? int'(lo_reload_i) : int'(hi_reload_i);
      m_ccnt = int'(car_reload_i); m_car = 0; m_hd = 0; m_ld = 0; m_cd = 0;
    end else begin
      m_hd = 0; m_ld = 0; m_cd = 0;
      if (tick_i) begin
        if (m_cnt == 0) begin
          if (m_ph == 1) m_hd = 1; else m_ld = 1;
          m_ph = 1 - m_ph;
          if (m_ph == 1) m_cnt = low_only_i ? int'(lo_reload_i) : int'(hi_reload_i);
          else           m_cnt = int'(lo_reload_i);
        end else m_cnt--;
        if (m_ccnt == 0) begin
          m_ccnt = int'(car_reload_i); m_car = 1 - m_car; m_cd = 1;
        end else m_ccnt--;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      int exp_pin;
      exp_pin = !en_i ? int'(port_bit_i) : (m_ph == 1 ? 1 : (mod_en_i ? m_car : 0));
      check(int'(pin_o) == exp_pin, cur_req, "pin", int'(pin_o), exp_pin);
      check(int'(hi_done_o) == m_hd, "R8", "hi_done", int'(hi_done_o), m_hd);
      check(int'(lo_done_o) == m_ld, "R8", "lo_done", int'(lo_done_o), m_ld);
      check(int'(car_done_o) == m_cd, "R4", "car_done", int'(car_done_o), m_cd);
    end
  end

  task automatic run(input int n, input int div);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      tick_i = (i % div) == 0;
    end
  endtask

  task automatic finish_run();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_ni = 1'b1;
    // R1: reset state and port passthrough
    cur_req = "R1";
    port_bit_i = 1'b1; run(3, 1);
    port_bit_i = 1'b0; run(3, 1);
    // R2: plain waveform, tick every cycle
    cur_req = "R2";
    hi_reload_i = 3; lo_reload_i = 5; car_reload_i = 2;
    en_i = 1'b1; run(60, 1);
    // R3: sparse ticks
    cur_req = "R3";
    run(90, 3);
    // R4: carrier independent while plain
    cur_req = "R4";
    car_reload_i = 4; run(50, 2);
    // R5: modulated low phase
    cur_req = "R5";
    mod_en_i = 1'b1; car_reload_i = 1; lo_reload_i = 9; run(80, 1);
    // R6: low-only ignores high reload
    cur_req = "R6";
    mod_en_i = 1'b0; low_only_i = 1'b1; hi_reload_i = 20; lo_reload_i = 2; run(60, 1);
    low_only_i = 1'b0; hi_reload_i = 4; run(30, 1);
    // R7: reload changed mid-phase
    cur_req = "R7";
    hi_reload_i = 6; lo_reload_i = 6; run(5, 1);
    hi_reload_i = 1; lo_reload_i = 2; run(40, 1);
    // R1: disable mid-waveform, port drives pin, restart
    cur_req = "R1";
    en_i = 1'b0; port_bit_i = 1'b1; run(4, 1);
    port_bit_i = 1'b0; run(3, 1);
    en_i = 1'b1; run(20, 1);
    // R2: boundary, zero reloads
    cur_req = "R2";
    hi_reload_i = 0; lo_reload_i = 0; car_reload_i = 0; run(20, 1);
    mod_en_i = 1'b1; cur_req = "R5"; run(20, 1);
    en_i = 1'b0; run(2, 1);
    finish_run();
  end
endmodule